// File: doc/BRIEF.md
# Systematic Reed-Solomon Parity Encoder

This block turns a stream of 8-bit data symbols into a systematic Reed-Solomon codeword with six check symbols. The code is RS(255,249) and corrects up to three symbol errors. Each data symbol goes to the output unchanged, one cycle after it is accepted. When the last data symbol of a block has been taken, six parity symbols follow and the final one is flagged as the end of the codeword. The parity is produced by a chain of six symbol registers that divides the message polynomial by the generator polynomial. The feedback path uses constant multipliers over GF(2^8).

The input is a valid/ready symbol port with a start-of-block flag. A data-count input is sampled together with that flag. A count below 249 gives a shortened codeword. The missing leading symbols count as zero, so they are neither sent nor clocked through the chain, and the parity comes out exactly as it would with those zeros in front. The output is a valid/last symbol stream with no backpressure. The input side is throttled only while parity is being emitted.

Top module: `rs_parity_enc`

## Requirements
- R1: While reset is asserted, and right after it is released, out_valid_o and out_last_o are 0 and in_ready_o is 1.
- R2: Each accepted data symbol of a block appears unchanged on out_data_o, with out_valid_o high and out_last_o low, in the cycle after it is accepted.
- R3: The six symbols emitted after the data are the remainder of d(x)·x^6 divided by g(x), with the highest-degree coefficient first. The field uses primitive polynomial 0x11D and alpha = 2, and g(x) has the roots alpha^0 to alpha^5. Evaluating the emitted codeword at each of these roots gives zero.
- R4: out_last_o is high on the sixth parity symbol only, and never on a data symbol or on any other parity symbol.
- R5: After the last data symbol is accepted, in_ready_o is low for exactly 6 cycles and then returns high. A start symbol presented at that point is accepted at once, so back-to-back codewords leave the output with no idle cycle.
- R6: cfg_k_i is sampled with the start symbol and gives the number of data symbols in the block. A value of 0 acts as 1, and a value above 249 acts as 249. The parity of a block of k symbols equals the parity of the 249-symbol block made of 249−k zero symbols followed by the same data.
- R7: An accepted symbol with in_sob_i high always starts a new block. It clears the parity state and the count, even partway through a block.
- R8: An accepted symbol with in_sob_i low, when no block is open, is ignored. It produces no output and does not change later parity.
- R9: Cycles with in_valid_i low inside a block leave the parity and the count unchanged, so idle gaps between data symbols give the same codeword as a gap-free block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input symbol valid |
| in_ready_o | output | 1 | Encoder can accept a symbol |
| in_sob_i | input | 1 | Symbol is the first of a block |
| in_data_i | input | 8 | Data symbol |
| cfg_k_i | input | 8 | Data symbols in the block, sampled with the start symbol |
| out_valid_o | output | 1 | Output symbol valid |
| out_data_o | output | 8 | Codeword symbol (data, then parity) |
| out_last_o | output | 1 | Final parity symbol of the codeword |

## Verification
A corrupted parity register or a wrong multiplier constant shows only at the end of a block. It appears within the six parity symbols that follow the last data symbol, as a mismatch against an independent polynomial division and as a nonzero syndrome. A wrong count shows as parity emitted too early or too late, a misplaced last flag, or a ready low window that is not six cycles long. It appears within one codeword. A failure to clear the state at a start symbol shows in the next block's parity, and the restart and ignored-symbol cases are aimed at exactly that.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam logic [SYM_W:0] GF_POLY = 9'h11D;

  typedef logic [SYM_W-1:0] sym_t;

  // multiply by alpha (x) modulo the field polynomial
  function automatic sym_t gf_xtime(sym_t a);
    sym_t s;
    s = {a[SYM_W-2:0], 1'b0};
    if (a[SYM_W-1]) s = s ^ GF_POLY[SYM_W-1:0];
    return s;
  endfunction

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t p;
    p = '0;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      p = gf_xtime(p);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic sym_t gf_alpha_pow(int e);
    sym_t r;
    r = sym_t'(1);
    for (int n = 0; n < e; n++) r = gf_xtime(r);
    return r;
  endfunction

  // coefficient idx (x^idx) of prod_{i<npar} (x + alpha^i); npar <= 32
  function automatic sym_t gf_gen_coef(int npar, int idx);
    sym_t g [0:32];
    sym_t root;
    for (int j = 0; j <= 32; j++) g[j] = '0;
    g[0] = sym_t'(1);
    for (int i = 0; i < npar; i++) begin
      root = gf_alpha_pow(i);
      for (int j = i + 1; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
    end
    return g[idx];
  endfunction
endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
  import rs_enc_pkg::*;
#(
  parameter sym_t COEF = 8'h01
) (
  input  sym_t a_i,
  output sym_t p_o
);
  sym_t terms [SYM_W];

  // column b of the constant matrix is COEF * alpha^b
  for (genvar b = 0; b < SYM_W; b++) begin : g_col
    localparam sym_t COL = gf_mul(gf_alpha_pow(b), COEF);
    assign terms[b] = a_i[b] ? COL : '0;
  end

  always_comb begin
    p_o = '0;
    for (int b = 0; b < SYM_W; b++) p_o = p_o ^ terms[b];
  end
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
  import rs_enc_pkg::*;
#(
  parameter int NPAR = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,    // with step_i: treat old state as zero
  input  logic step_i,   // absorb data_i
  input  logic shift_i,  // shift out, feedback forced to zero
  input  sym_t data_i,
  output sym_t top_o
);
  sym_t par_q [NPAR];
  sym_t base  [NPAR];
  sym_t prod  [NPAR];
  sym_t nxt   [NPAR];
  sym_t fb;

  always_comb begin
    for (int i = 0; i < NPAR; i++) base[i] = clr_i ? '0 : par_q[i];
    fb = step_i ? (data_i ^ base[NPAR-1]) : '0;
  end

  for (genvar i = 0; i < NPAR; i++) begin : g_tap
    rs_gf_cmul #(.COEF(gf_gen_coef(NPAR, i))) u_mul (
      .a_i(fb),
      .p_o(prod[i])
    );
    if (i == 0) begin : g_low
      assign nxt[i] = prod[i];
    end else begin : g_mid
      assign nxt[i] = base[i-1] ^ prod[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPAR; i++) par_q[i] <= '0;
    end else if (step_i || shift_i) begin
      for (int i = 0; i < NPAR; i++) par_q[i] <= nxt[i];
    end
  end

  assign top_o = par_q[NPAR-1];

  AST_SHIFT_FILLS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> par_q[0] == '0); // R3
  AST_STEP_SHIFT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !shift_i); // R5
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i || shift_i) |=> $stable(par_q[NPAR-1])); // R9
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl #(
  parameter int NPAR  = 6,
  parameter int KMAX  = 249,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_sob_i,
  input  logic [CNT_W-1:0] cfg_k_i,
  output logic             in_ready_o,
  output logic             step_o,
  output logic             clr_o,
  output logic             shift_o,
  output logic             par_last_o
);
  localparam int PW = (NPAR > 1) ? $clog2(NPAR) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAR} st_e;

  st_e              state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [PW-1:0]    pcnt_q, pcnt_d;
  logic [CNT_W-1:0] k_eff;
  logic             acc, start, cont;

  always_comb begin
    if (cfg_k_i == '0)                 k_eff = CNT_W'(1);
    else if (cfg_k_i > CNT_W'(KMAX))   k_eff = CNT_W'(KMAX);
    else                               k_eff = cfg_k_i;
  end

  assign in_ready_o = (state_q != ST_PAR);
  assign acc        = in_valid_i && in_ready_o;
  assign start      = acc && in_sob_i;
  assign cont       = acc && !in_sob_i && (state_q == ST_DATA);
  assign step_o     = start || cont;
  assign clr_o      = start;
  assign shift_o    = (state_q == ST_PAR);
  assign par_last_o = shift_o && (pcnt_q == PW'(NPAR - 1));

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    pcnt_d  = pcnt_q;
    if (start) begin
      if (k_eff == CNT_W'(1)) begin
        state_d = ST_PAR;
        pcnt_d  = '0;
      end else begin
        state_d = ST_DATA;
        rem_d   = k_eff - CNT_W'(1);
      end
    end else if (cont) begin
      if (rem_q == CNT_W'(1)) begin
        state_d = ST_PAR;
        pcnt_d  = '0;
      end
      rem_d = rem_q - CNT_W'(1);
    end else if (shift_o) begin
      pcnt_d = pcnt_q + PW'(1);
      if (par_last_o) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      pcnt_q  <= pcnt_d;
    end
  end

  AST_REM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (rem_q != '0 && rem_q < CNT_W'(KMAX))); // R6
  AST_PCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |-> (pcnt_q < PW'(NPAR))); // R4
  AST_PAR_RUNS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && !par_last_o) |=> shift_o); // R5
endmodule

// File: rtl/rs_parity_enc.sv
module rs_parity_enc
  import rs_enc_pkg::*;
#(
  parameter  int NPAR  = 6,
  parameter  int KMAX  = 249,
  localparam int CNT_W = $clog2(KMAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             in_sob_i,
  input  logic [SYM_W-1:0] in_data_i,
  input  logic [CNT_W-1:0] cfg_k_i,
  output logic             out_valid_o,
  output logic [SYM_W-1:0] out_data_o,
  output logic             out_last_o
);
  logic step, clr, shift, par_last;
  sym_t par_top;

  rs_enc_ctrl #(.NPAR(NPAR), .KMAX(KMAX), .CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(in_valid_i),
    .in_sob_i  (in_sob_i),
    .cfg_k_i   (cfg_k_i),
    .in_ready_o(in_ready_o),
    .step_o    (step),
    .clr_o     (clr),
    .shift_o   (shift),
    .par_last_o(par_last)
  );

  rs_parity_lfsr #(.NPAR(NPAR)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (step),
    .shift_i(shift),
    .data_i (in_data_i),
    .top_o  (par_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else if (step) begin
      out_valid_o <= 1'b1;
      out_data_o  <= in_data_i;
      out_last_o  <= 1'b0;
    end else if (shift) begin
      out_valid_o <= 1'b1;
      out_data_o  <= par_top;
      out_last_o  <= par_last;
    end else begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
    end
  end

  AST_LAST_HAS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o); // R4
  AST_LAST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> !out_last_o); // R4
  AST_READY_BACK_AT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_ready_o) |-> out_last_o); // R5
  AST_PARITY_EMITTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> out_valid_o); // R5
  AST_START_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_sob_i) |=>
      (out_valid_o && !out_last_o && out_data_o == $past(in_data_i))); // R2
endmodule

// File: tb/rs_parity_enc_test.sv
`timescale 1ns/1ps
module rs_parity_enc_test;
  localparam int NP = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sob = 1'b0;
  logic [7:0] in_data = '0, cfg_k = 8'd1;
  logic       in_ready, out_valid, out_last;
  logic [7:0] out_data;

  int checks = 0, errors = 0, cyc = 0, cap_n = 0;
  logic [7:0] cap_d [0:1023];
  bit         cap_l [0:1023];
  int         cap_c [0:1023];
  logic [7:0] msg   [0:255];
  logic [7:0] gd    [0:NP];
  logic [7:0] last_par [0:NP-1];

  // {k, seed, gap}; seed 0 means all-zero data
  localparam logic [23:0] VEC [8] = '{
    {8'd249, 8'h5A, 8'd0}, {8'd1,   8'h33, 8'd0}, {8'd6,   8'h01, 8'd2},
    {8'd17,  8'hC3, 8'd1}, {8'd100, 8'h00, 8'd0}, {8'd2,   8'h7E, 8'd3},
    {8'd248, 8'h91, 8'd0}, {8'd40,  8'hE4, 8'd0}};

  rs_parity_enc uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_sob_i(in_sob), .in_data_i(in_data), .cfg_k_i(cfg_k),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last));

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(negedge clk) if (rst_n && out_valid && cap_n < 1024) begin
    cap_d[cap_n] = out_data; cap_l[cap_n] = out_last; cap_c[cap_n] = cyc; cap_n++;
  end

  function automatic logic [7:0] mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 8'h00, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] apow(int e);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < e; i++) r = mul(r, 8'h02);
    return r;
  endfunction

  function automatic logic [7:0] pat(logic [7:0] seed, int i);
    int v = int'(seed) * (i + 1) * 7 + i * i;
    return (seed == 0) ? 8'h00 : v[7:0];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] d, logic sob);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sob = sob;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic send_block(int k, logic [7:0] seed, int gap, int nsend);
    cfg_k = 8'(k);
    for (int i = 0; i < nsend; i++) begin
      msg[i] = pat(seed, i);
      push(msg[i], i == 0);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); in_valid = 1'b0;
      end
    end
    @(negedge clk); in_valid = 1'b0; in_sob = 1'b0;
  endtask

  task automatic wait_out(int n);
    for (int t = 0; t < 3000 && cap_n < n; t++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // compares cap[base..] with msg[0..k-1] plus reference parity
  task automatic expect_block(int k, int base, string tag);
    logic [7:0] w [0:260];
    logic [7:0] c, s;
    int bad;
    bad = -1;
    for (int i = 0; i < k; i++) if (bad < 0 && cap_d[base+i] != msg[i]) bad = i;
    chk(bad < 0, "R2", {tag, " data"}, bad < 0 ? 0 : cap_d[base+bad], bad < 0 ? 0 : msg[bad]);
    for (int i = 0; i < k + NP; i++) w[i] = (i < k) ? msg[i] : 8'h00;
    for (int i = 0; i < k; i++) begin
      c = w[i];
      for (int j = 1; j <= NP; j++) w[i+j] ^= mul(c, gd[j]);
    end
    bad = -1;
    for (int j = 0; j < NP; j++) begin
      last_par[j] = cap_d[base+k+j];
      if (bad < 0 && cap_d[base+k+j] != w[k+j]) bad = j;
    end
    chk(bad < 0, "R3", {tag, " parity"}, bad < 0 ? 0 : cap_d[base+k+bad], bad < 0 ? 0 : w[k+bad]);
    bad = -1;
    for (int j = 0; j < NP; j++) begin
      s = 8'h00;
      for (int i = 0; i < k + NP; i++) s = mul(s, apow(j)) ^ cap_d[base+i];
      if (bad < 0 && s != 0) bad = j;
    end
    chk(bad < 0, "R3", {tag, " syndrome"}, bad, -1);
    bad = -1;
    for (int i = 0; i < k + NP; i++) if (bad < 0 && cap_l[base+i] != (i == k + NP - 1)) bad = i;
    chk(bad < 0, "R4", {tag, " last position"}, bad, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] p5 [0:NP-1];
    int n;
    for (int j = 0; j <= NP; j++) gd[j] = 8'h00;
    gd[0] = 8'h01;
    for (int d = 0; d < NP; d++)
      for (int j = d + 1; j >= 1; j--) gd[j] ^= mul(gd[j-1], apow(d));

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !out_last && in_ready, "R1", "after release",
        {out_valid, out_last, in_ready}, 1);

    // R8 symbols without start outside a block are ignored
    for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i), 1'b0);
    @(negedge clk); in_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(cap_n == 0, "R8", "no output for stray symbols", cap_n, 0);

    // vector table (R2 R3 R4 R9, shortened R6)
    for (int v = 0; v < 8; v++) begin
      cap_n = 0;
      send_block(int'(VEC[v][23:16]), VEC[v][15:8], int'(VEC[v][7:0]), int'(VEC[v][23:16]));
      wait_out(int'(VEC[v][23:16]) + NP);
      chk(cap_n == int'(VEC[v][23:16]) + NP, "R2", "symbol count", cap_n, int'(VEC[v][23:16]) + NP);
      expect_block(int'(VEC[v][23:16]), 0, $sformatf("vec%0d", v));
    end

    // R6 shortened parity equals zero-prefixed full block
    cap_n = 0;
    send_block(5, 8'h6B, 0, 5);
    wait_out(5 + NP);
    for (int j = 0; j < NP; j++) p5[j] = cap_d[5+j];
    cap_n = 0;
    cfg_k = 8'd249;
    for (int i = 0; i < 249; i++) push(i < 244 ? 8'h00 : pat(8'h6B, i - 244), i == 0);
    @(negedge clk); in_valid = 1'b0; in_sob = 1'b0;
    wait_out(249 + NP);
    n = 0;
    for (int j = 0; j < NP; j++) if (cap_d[249+j] != p5[j]) n++;
    chk(n == 0, "R6", "shortened vs zero prefix", n, 0);

    // R6 count of zero acts as one
    cap_n = 0;
    send_block(0, 8'h29, 0, 1);
    wait_out(1 + NP);
    chk(cap_n == 1 + NP, "R6", "k=0 length", cap_n, 1 + NP);
    expect_block(1, 0, "k0");

    // R5 ready low exactly six cycles after last data
    cap_n = 0;
    send_block(3, 8'h17, 0, 3);
    n = 0;
    while (!in_ready && n < 50) begin n++; @(negedge clk); end
    chk(n == NP, "R5", "ready low cycles", n, NP);
    wait_out(3 + NP);

    // R5 back-to-back blocks, no idle output cycle
    cap_n = 0;
    send_block(3, 8'h44, 0, 3);
    send_block(4, 8'h55, 0, 4);
    wait_out(3 + NP + 4 + NP);
    chk(cap_n == 19, "R5", "b2b count", cap_n, 19);
    chk(cap_c[18] - cap_c[0] == 18, "R5", "b2b output span", cap_c[18] - cap_c[0], 18);
    expect_block(4, 3 + NP, "b2b second");
    for (int i = 0; i < 3; i++) msg[i] = pat(8'h44, i);
    expect_block(3, 0, "b2b first");

    // R7 start symbol mid-block restarts
    cap_n = 0;
    send_block(10, 8'h3C, 0, 5);
    send_block(4, 8'hB2, 1, 4);
    wait_out(5 + 4 + NP);
    chk(cap_n == 15, "R7", "restart count", cap_n, 15);
    expect_block(4, 5, "restart");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule